// File: doc/BRIEF.md
# Transmit Command-Word Frame Assembler

This block sits behind a host's transmit data port. The host writes 32-bit words, and the block turns them into frames. Every buffer opens with two command words. The first word gives the buffer length, a byte offset at the start, an end-alignment code and three flags: start of frame, end of frame, and notify-on-completion. The second word carries a 16-bit tag. Payload words follow. Their bytes are packed least significant lane first. The block discards the lead-in offset bytes and presents the remaining bytes as lane-masked words on an output stream. It also swallows the filler words that the end-alignment code asks for.

When a buffer marked end-of-frame has been fully consumed, the block signals the frame end. It hands the tag, shifted into the upper half of a word, to an external completion-status queue. It keeps track of how many entries that queue holds, so it can raise a pulse when the queue becomes full and refuse pushes while it stays full. A host write that arrives while the external data storage reports full is dropped and flagged. A frame has a hard byte limit: surplus bytes are masked off and flagged. A flush input aborts the current buffer.

Top module: `txasm_top`

## Requirements
- R1: The first word of a buffer is command A. It is masked with 0x831F37FF and decoded as follows: length bits 10:0, start offset bits 20:16, alignment code bits 25:24, end-of-frame bit 12, start-of-frame bit 13, notify bit 31. Reserved bits have no effect. Command A and the following command B (tag in bits 31:16) produce no output bytes.
- R2: Each payload word appears on `out_data_o` unchanged. Byte lane i is bits 8i+7:8i, and lane 0 is the earliest byte. `out_keep_o[i]` marks the lanes that belong to the frame. `out_valid_o` is high exactly when at least one lane is kept.
- R3: The first `offset` bytes of the buffer's payload stream (0 to 31) are discarded, even when they fill whole words. After that, exactly `length` bytes are kept.
- R4: The payload spans ceil((offset+length)/4) words. Alignment code 1 adds filler words up to a multiple of 4 payload words, and code 2 up to a multiple of 8. Codes 0 and 3 add none. Command words are not counted. Filler words produce no output.
- R5: When the final payload or filler word of an end-of-frame buffer is taken, `frame_end_o` pulses. The next word is then decoded as command A. A buffer with zero length, zero offset and no filler completes on its command B.
- R6: `irq_txdone_o` pulses when any buffer whose notify bit is set is completed.
- R7: Completing an end-of-frame buffer pushes {tag, 16'h0000} through `stat_push_o`/`stat_data_o`. The push happens in the same cycle as `frame_end_o`.
- R8: The status queue holds at most STAT_DEPTH (512) entries. `stat_pop_i` removes one entry. `irq_stat_full_o` pulses with the push that brings the count to 512. No push occurs while the count is 512.
- R9: A write that coincides with `fifo_full_i` pulses `irq_overflow_o` and is otherwise ignored: the parser's position does not change.
- R10: A frame holds at most MAX_FRAME (2048) bytes. Further bytes are masked off in `out_keep_o`, and `err_frame_long_o` pulses with the word that carried them.
- R11: The start-of-frame bit clears the frame byte count when command B is taken. Without it, the count continues from the previous buffer.
- R12: After reset, and after a cycle with `flush_i` high, the next word is decoded as command A and the frame byte count is zero. A write in a flush cycle is discarded.
- R13: Every result of a write appears in the cycle after the clock edge that takes the write. A cycle without a taken write produces no output strobe other than the overflow pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Abort current buffer, clear frame count |
| wr_valid_i | input | 1 | Host word write strobe |
| wr_data_i | input | 32 | Host word |
| fifo_full_i | input | 1 | External data storage full; write is rejected |
| stat_pop_i | input | 1 | One entry removed from the status queue |
| out_valid_o | output | 1 | Output word carries kept bytes |
| out_data_o | output | 32 | Payload word |
| out_keep_o | output | 4 | Kept byte lanes |
| frame_end_o | output | 1 | Frame completed |
| irq_txdone_o | output | 1 | Notify-on-completion pulse |
| stat_push_o | output | 1 | Status entry push |
| stat_data_o | output | 32 | Status entry {tag, 16'h0} |
| irq_stat_full_o | output | 1 | Status queue just became full |
| irq_overflow_o | output | 1 | Write rejected because storage full |
| err_frame_long_o | output | 1 | Bytes dropped past the frame limit |

## Verification
Every outcome of a host word is registered once. It is visible in exactly the cycle after the edge that takes the word. This holds for payload lanes, frame end, notify, status push, queue-full, overflow and length errors alike. The driver stamps each expected record with the cycle number at which it falls due. The monitor samples at the falling edge and compares that cycle's outputs against the record. In cycles with no record due, it checks that every strobe is low. As a result, a result that arrives one cycle early or one cycle late is reported.

// File: rtl/txasm_pkg.sv
package txasm_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;

    localparam logic [31:0] CMD_A_MASK = 32'h831F_37FF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } parse_state_e;

    typedef struct packed {
        logic        notify;
        logic [1:0]  align;
        logic [4:0]  offset;
        logic        first;
        logic        last;
        logic [10:0] length;
    } cmd_a_t;

    function automatic cmd_a_t decode_cmd_a(input logic [31:0] w);
        logic [31:0] m;
        cmd_a_t      c;
        m        = w & CMD_A_MASK;
        c.notify = m[31];
        c.align  = m[25:24];
        c.offset = m[20:16];
        c.first  = m[13];
        c.last   = m[12];
        c.length = m[10:0];
        return c;
    endfunction

    function automatic logic [2:0] filler_words(input logic [1:0] align,
                                                input logic [9:0] nwords);
        logic [2:0] f;
        case (align)
            2'd1:    f = {1'b0, (~nwords[1:0]) + 2'd1};
            2'd2:    f = (~nwords[2:0]) + 3'd1;
            default: f = 3'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/txasm_lanes.sv
module txasm_lanes
    import txasm_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 2048,
    localparam int unsigned FCNT_W   = $clog2(MAX_FRAME + 1)
) (
    input  logic [11:0]       pos_i,
    input  logic [4:0]        offset_i,
    input  logic [10:0]       length_i,
    input  logic [FCNT_W-1:0] fcnt_i,
    output logic [LANES-1:0]  keep_o,
    output logic [2:0]        nkept_o,
    output logic              dropped_o
);
    logic [12:0]      hi;
    logic [LANES-1:0] inbuf;

    assign hi = {8'd0, offset_i} + {2'd0, length_i};

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [12:0] idx;
            assign idx      = {1'b0, pos_i} + 13'(g);
            assign inbuf[g] = (idx >= {8'd0, offset_i}) && (idx < hi);
        end
    endgenerate

    always_comb begin
        logic [FCNT_W:0] run;
        run     = {1'b0, fcnt_i};
        keep_o  = '0;
        nkept_o = 3'd0;
        for (int i = 0; i < LANES; i++) begin
            if (inbuf[i] && (run < (FCNT_W+1)'(MAX_FRAME))) begin
                keep_o[i] = 1'b1;
                run       = run + 1'b1;
                nkept_o   = nkept_o + 3'd1;
            end
        end
    end

    assign dropped_o = |(inbuf & ~keep_o);

endmodule

// File: rtl/txasm_parser.sv
module txasm_parser
    import txasm_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 2048,
    localparam int unsigned FCNT_W   = $clog2(MAX_FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              fifo_full_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    output logic [LANES-1:0]  out_keep_o,
    output logic              frame_end_o,
    output logic              irq_txdone_o,
    output logic              irq_overflow_o,
    output logic              err_long_o,
    output logic              end_now_o,
    output logic [15:0]       tag_now_o
);
    parse_state_e      state;
    cmd_a_t            cmd_q;
    logic [15:0]       tag_q;
    logic [11:0]       pos_q;
    logic [9:0]        words_left;
    logic [2:0]        fill_left;
    logic [FCNT_W-1:0] fcnt;

    logic              take;
    logic [11:0]       span;
    logic [9:0]        nwords;
    logic [2:0]        nfill;
    logic              b_done;
    logic              last_word;
    logic              finishing;
    logic [LANES-1:0]  keep_c;
    logic [2:0]        nkept_c;
    logic              dropped_c;

    assign take      = wr_valid_i && !fifo_full_i && !flush_i;
    assign span      = {1'b0, cmd_q.length} + {7'd0, cmd_q.offset} + 12'd3;
    assign nwords    = span[11:2];
    assign nfill     = filler_words(cmd_q.align, nwords);
    assign b_done    = (nwords == 10'd0) && (nfill == 3'd0);
    assign last_word = ((words_left == 10'd1) && (fill_left == 3'd0)) ||
                       ((words_left == 10'd0) && (fill_left == 3'd1));
    assign finishing = (state == ST_TAG && b_done) || (state == ST_DATA && last_word);
    assign end_now_o = take && finishing && cmd_q.last;
    assign tag_now_o = (state == ST_TAG) ? wr_data_i[31:16] : tag_q;

    txasm_lanes #(.MAX_FRAME(MAX_FRAME)) u_lanes (
        .pos_i     (pos_q),
        .offset_i  (cmd_q.offset),
        .length_i  (cmd_q.length),
        .fcnt_i    (fcnt),
        .keep_o    (keep_c),
        .nkept_o   (nkept_c),
        .dropped_o (dropped_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            cmd_q          <= '0;
            tag_q          <= '0;
            pos_q          <= '0;
            words_left     <= '0;
            fill_left      <= '0;
            fcnt           <= '0;
            out_valid_o    <= 1'b0;
            out_data_o     <= '0;
            out_keep_o     <= '0;
            frame_end_o    <= 1'b0;
            irq_txdone_o   <= 1'b0;
            irq_overflow_o <= 1'b0;
            err_long_o     <= 1'b0;
        end else begin
            out_valid_o    <= 1'b0;
            out_keep_o     <= '0;
            frame_end_o    <= 1'b0;
            irq_txdone_o   <= 1'b0;
            err_long_o     <= 1'b0;
            irq_overflow_o <= wr_valid_i && fifo_full_i;
            if (flush_i) begin
                state <= ST_IDLE;
                fcnt  <= '0;
            end else if (take) begin
                case (state)
                    ST_IDLE: begin
                        cmd_q <= decode_cmd_a(wr_data_i);
                        state <= ST_TAG;
                    end
                    ST_TAG: begin
                        tag_q      <= wr_data_i[31:16];
                        pos_q      <= '0;
                        words_left <= nwords;
                        fill_left  <= nfill;
                        if (cmd_q.first) fcnt <= '0;
                        state      <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (words_left != 10'd0) begin
                            out_valid_o <= |keep_c;
                            out_data_o  <= wr_data_i;
                            out_keep_o  <= keep_c;
                            err_long_o  <= dropped_c;
                            fcnt        <= fcnt + FCNT_W'(nkept_c);
                            pos_q       <= pos_q + 12'd4;
                            words_left  <= words_left - 10'd1;
                        end else begin
                            fill_left   <= fill_left - 3'd1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
                if (finishing) begin
                    state        <= ST_IDLE;
                    frame_end_o  <= cmd_q.last;
                    irq_txdone_o <= cmd_q.notify;
                end
            end
        end
    end

endmodule

// File: rtl/txasm_status.sv
module txasm_status #(
    parameter int unsigned STAT_DEPTH = 512,
    localparam int unsigned SCNT_W    = $clog2(STAT_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        end_i,
    input  logic [15:0] tag_i,
    input  logic        pop_i,
    output logic        push_o,
    output logic [31:0] data_o,
    output logic        full_irq_o
);
    logic [SCNT_W-1:0] occ;
    logic              push;
    logic              pop_ok;

    assign push   = end_i && (occ < SCNT_W'(STAT_DEPTH));
    assign pop_ok = pop_i && (occ != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ        <= '0;
            push_o     <= 1'b0;
            data_o     <= '0;
            full_irq_o <= 1'b0;
        end else begin
            if (push && !pop_ok)      occ <= occ + 1'b1;
            else if (!push && pop_ok) occ <= occ - 1'b1;
            push_o     <= push;
            data_o     <= push ? {tag_i, 16'h0000} : 32'h0;
            full_irq_o <= push && !pop_ok && (occ == SCNT_W'(STAT_DEPTH - 1));
        end
    end

endmodule

// File: rtl/txasm_top.sv
module txasm_top
    import txasm_pkg::*;
#(
    parameter int unsigned MAX_FRAME  = 2048,
    parameter int unsigned STAT_DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush_i,
    input  logic        wr_valid_i,
    input  logic [31:0] wr_data_i,
    input  logic        fifo_full_i,
    input  logic        stat_pop_i,
    output logic        out_valid_o,
    output logic [31:0] out_data_o,
    output logic [3:0]  out_keep_o,
    output logic        frame_end_o,
    output logic        irq_txdone_o,
    output logic        stat_push_o,
    output logic [31:0] stat_data_o,
    output logic        irq_stat_full_o,
    output logic        irq_overflow_o,
    output logic        err_frame_long_o
);
    logic        end_now;
    logic [15:0] tag_now;

    txasm_parser #(.MAX_FRAME(MAX_FRAME)) u_parser (
        .clk            (clk),
        .rst            (rst),
        .flush_i        (flush_i),
        .wr_valid_i     (wr_valid_i),
        .wr_data_i      (wr_data_i),
        .fifo_full_i    (fifo_full_i),
        .out_valid_o    (out_valid_o),
        .out_data_o     (out_data_o),
        .out_keep_o     (out_keep_o),
        .frame_end_o    (frame_end_o),
        .irq_txdone_o   (irq_txdone_o),
        .irq_overflow_o (irq_overflow_o),
        .err_long_o     (err_frame_long_o),
        .end_now_o      (end_now),
        .tag_now_o      (tag_now)
    );

    txasm_status #(.STAT_DEPTH(STAT_DEPTH)) u_status (
        .clk        (clk),
        .rst        (rst),
        .end_i      (end_now),
        .tag_i      (tag_now),
        .pop_i      (stat_pop_i),
        .push_o     (stat_push_o),
        .data_o     (stat_data_o),
        .full_irq_o (irq_stat_full_o)
    );

endmodule

// File: rtl/txasm_checker.sv
module txasm_checker (
    input logic        clk,
    input logic        rst,
    input logic        flush_i,
    input logic        wr_valid_i,
    input logic        fifo_full_i,
    input logic        out_valid_o,
    input logic [3:0]  out_keep_o,
    input logic        frame_end_o,
    input logic        irq_txdone_o,
    input logic        stat_push_o,
    input logic [31:0] stat_data_o,
    input logic        irq_stat_full_o,
    input logic        irq_overflow_o,
    input logic        err_frame_long_o
);
    assert_valid_has_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (out_keep_o != 4'b0000));

    assert_push_on_frame_end_R7: assert property (@(posedge clk) disable iff (rst)
        stat_push_o |-> (frame_end_o && stat_data_o[15:0] == 16'h0000));

    assert_full_with_push_R8: assert property (@(posedge clk) disable iff (rst)
        irq_stat_full_o |-> stat_push_o);

    assert_no_overflow_consume_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && fifo_full_i) |=> (irq_overflow_o && !out_valid_o && !frame_end_o));

    assert_flush_discards_R12: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!out_valid_o && !frame_end_o && !irq_txdone_o && !err_frame_long_o));

    assert_quiet_without_write_R13: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid_i && !fifo_full_i) |=>
            (!out_valid_o && !frame_end_o && !irq_txdone_o && !stat_push_o && !err_frame_long_o));

endmodule

bind txasm_top txasm_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .flush_i          (flush_i),
    .wr_valid_i       (wr_valid_i),
    .fifo_full_i      (fifo_full_i),
    .out_valid_o      (out_valid_o),
    .out_keep_o       (out_keep_o),
    .frame_end_o      (frame_end_o),
    .irq_txdone_o     (irq_txdone_o),
    .stat_push_o      (stat_push_o),
    .stat_data_o      (stat_data_o),
    .irq_stat_full_o  (irq_stat_full_o),
    .irq_overflow_o   (irq_overflow_o),
    .err_frame_long_o (err_frame_long_o)
);

// File: tb/tb_txasm_top.sv
`timescale 1ns/1ps
module tb_txasm_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        fifo_full_i = 1'b0;
    logic        stat_pop_i = 1'b0;
    logic        out_valid_o;
    logic [31:0] out_data_o;
    logic [3:0]  out_keep_o;
    logic        frame_end_o;
    logic        irq_txdone_o;
    logic        stat_push_o;
    logic [31:0] stat_data_o;
    logic        irq_stat_full_o;
    logic        irq_overflow_o;
    logic        err_frame_long_o;

    txasm_top dut (
        .clk(clk), .rst(rst), .flush_i(flush_i), .wr_valid_i(wr_valid_i),
        .wr_data_i(wr_data_i), .fifo_full_i(fifo_full_i), .stat_pop_i(stat_pop_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_keep_o(out_keep_o),
        .frame_end_o(frame_end_o), .irq_txdone_o(irq_txdone_o),
        .stat_push_o(stat_push_o), .stat_data_o(stat_data_o),
        .irq_stat_full_o(irq_stat_full_o), .irq_overflow_o(irq_overflow_o),
        .err_frame_long_o(err_frame_long_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          due;
        bit          v;
        logic [31:0] d;
        logic [3:0]  k;
        bit          fe, dn, ps;
        logic [31:0] pd;
        bit          sf, ov, er;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   fcount = 0;
    int   occ = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t blank(string req);
        exp_t e;
        e.due = 0; e.v = 0; e.d = '0; e.k = '0; e.fe = 0; e.dn = 0; e.ps = 0;
        e.pd = '0; e.sf = 0; e.ov = 0; e.er = 0; e.req = req;
        return e;
    endfunction

    // monitor: compares each due record, otherwise expects quiet strobes
    always @(negedge clk) begin
        if (!rst && !finished) begin
            exp_t e;
            bit   bad;
            if (q.size() > 0 && q[0].due == cyc) begin
                e = q.pop_front();
                checks++;
            end else begin
                e = blank("R13");
            end
            bad = (out_valid_o !== e.v) || (out_keep_o !== e.k) ||
                  (e.v && out_data_o !== e.d) || (frame_end_o !== e.fe) ||
                  (irq_txdone_o !== e.dn) || (stat_push_o !== e.ps) ||
                  (e.ps && stat_data_o !== e.pd) || (irq_stat_full_o !== e.sf) ||
                  (irq_overflow_o !== e.ov) || (err_frame_long_o !== e.er);
            if (bad) begin
                if (e.due == 0) checks++;
                errors++;
                $display("FAIL %s cyc=%0d actual v%b d%h k%b fe%b dn%b ps%b pd%h sf%b ov%b er%b expected v%b d%h k%b fe%b dn%b ps%b pd%h sf%b ov%b er%b",
                         e.req, cyc, out_valid_o, out_data_o, out_keep_o, frame_end_o,
                         irq_txdone_o, stat_push_o, stat_data_o, irq_stat_full_o,
                         irq_overflow_o, err_frame_long_o,
                         e.v, e.d, e.k, e.fe, e.dn, e.ps, e.pd, e.sf, e.ov, e.er);
            end
        end
    end

    task automatic put(input logic [31:0] w, input logic full, input exp_t e);
        @(posedge clk); #1;
        wr_valid_i  = 1'b1;
        wr_data_i   = w;
        fifo_full_i = full;
        e.due = cyc + 1;
        q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        wr_valid_i  = 1'b0;
        fifo_full_i = 1'b0;
    endtask

    task automatic do_flush();
        @(posedge clk); #1;
        wr_valid_i = 1'b0;
        flush_i    = 1'b1;
        fcount     = 0;
        @(posedge clk); #1;
        flush_i    = 1'b0;
    endtask

    task automatic do_pop();
        @(posedge clk); #1;
        wr_valid_i = 1'b0;
        stat_pop_i = 1'b1;
        if (occ > 0) occ--;
        @(posedge clk); #1;
        stat_pop_i = 1'b0;
    endtask

    // completion effects of a buffer, from R5..R8
    function automatic exp_t finish_rec(exp_t e, bit ls, bit ioc, logic [15:0] tag);
        e.fe = ls;
        e.dn = ioc;
        if (ls && occ < 512) begin
            e.ps = 1;
            e.pd = {tag, 16'h0000};
            e.sf = (occ == 511);
            occ++;
        end
        return e;
    endfunction

    task automatic send_buf(input int size, input int off, input int align,
                            input bit fs, input bit ls, input bit ioc,
                            input logic [15:0] tag, input int ovf_at, input string req);
        int          n;
        int          pad;
        logic [31:0] aw;
        exp_t        e;
        n   = (size + off + 3) / 4;
        pad = (align == 1) ? (4 - n % 4) % 4 : (align == 2) ? (8 - n % 8) % 8 : 0;
        aw  = {ioc, 5'b0, 2'(align), 3'b0, 5'(off), 2'b0, fs, ls, 1'b0, 11'(size)};
        aw  = aw | 32'h7CE0_C800;   // reserved bits set: must be ignored (R1)
        put(aw, 1'b0, blank("R1"));
        if (fs) fcount = 0;          // R11
        e = blank(req);
        if (n == 0 && pad == 0) e = finish_rec(e, ls, ioc, tag);
        put({tag, 16'hBEEF}, 1'b0, e);
        for (int j = 0; j < n; j++) begin
            logic [31:0] w;
            if (j == ovf_at) begin
                e = blank("R9");
                e.ov = 1;
                put(32'hDEAD_0000 | 32'(j), 1'b1, e);
            end
            e = blank(req);
            for (int i = 0; i < 4; i++) begin
                int p;
                p = 4 * j + i;
                w[8*i +: 8] = 8'(p * 7 + tag[7:0]);
                if (p >= off && p < off + size) begin
                    if (fcount < 2048) begin
                        e.k[i] = 1'b1;
                        fcount++;
                    end else begin
                        e.er = 1;
                    end
                end
            end
            e.v = |e.k;
            e.d = w;
            if (j == n - 1 && pad == 0) e = finish_rec(e, ls, ioc, tag);
            put(w, 1'b0, e);
        end
        for (int p = 0; p < pad; p++) begin
            e = blank("R4");
            if (p == pad - 1) e = finish_rec(e, ls, ioc, tag);
            put(32'hF111_0000 | 32'(p), 1'b0, e);
        end
        idle();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({out_valid_o, out_keep_o, frame_end_o, irq_txdone_o, stat_push_o,
             irq_stat_full_o, irq_overflow_o, err_frame_long_o} !== '0) begin
            errors++;
            $display("FAIL R12 reset outputs actual nonzero expected zero");
        end
        // R2 R5 R6 R7: aligned frame
        send_buf(8, 0, 0, 1, 1, 1, 16'h1234, -1, "R2");
        // R3: small offset
        send_buf(6, 3, 0, 1, 1, 0, 16'h2001, -1, "R3");
        // R3: offset spanning whole words
        send_buf(5, 9, 0, 1, 1, 0, 16'h2002, -1, "R3");
        send_buf(3, 31, 0, 1, 1, 1, 16'h2003, -1, "R3");
        // R4: alignment codes
        send_buf(4, 0, 1, 1, 1, 0, 16'h4001, -1, "R4");
        send_buf(12, 0, 2, 1, 1, 1, 16'h4002, -1, "R4");
        send_buf(10, 1, 3, 1, 1, 0, 16'h4003, -1, "R4");
        send_buf(20, 2, 1, 1, 1, 0, 16'h4004, -1, "R4");
        // R5 R6: multi-segment, notify on non-final buffer
        send_buf(7, 1, 0, 1, 0, 1, 16'h5001, -1, "R6");
        send_buf(9, 0, 0, 0, 1, 0, 16'h5002, -1, "R5");
        // R5: empty buffer completes on command B
        send_buf(0, 0, 0, 1, 1, 1, 16'h5003, -1, "R5");
        // R9: rejected write mid-buffer leaves parsing intact
        send_buf(16, 2, 0, 1, 1, 0, 16'h9001, 2, "R9");
        // R10: frame limit
        send_buf(2044, 0, 0, 1, 0, 0, 16'hA001, -1, "R10");
        send_buf(8, 0, 0, 0, 1, 0, 16'hA002, -1, "R10");
        // R11: start-of-frame clears the count
        send_buf(2044, 0, 0, 1, 0, 0, 16'hB001, -1, "R11");
        send_buf(8, 0, 0, 1, 1, 0, 16'hB002, -1, "R11");
        // R12: flush mid-buffer
        send_buf(2044, 0, 0, 1, 0, 0, 16'hC001, -1, "R12");
        begin
            exp_t e;
            put(32'h0000_1064, 1'b0, blank("R12"));   // A: length 100, end-of-frame
            put(32'hC002_0000, 1'b0, blank("R12"));
            e = blank("R12");
            e.v = 1; e.k = 4'hF; e.d = 32'h0403_0201;
            fcount += 4;
            put(32'h0403_0201, 1'b0, e);
            idle();
        end
        do_flush();
        send_buf(8, 0, 0, 0, 1, 0, 16'hC003, -1, "R12");
        // R8: fill the status queue
        while (occ < 512) send_buf(4, 0, 0, 1, 1, 0, 16'(occ), -1, "R8");
        send_buf(4, 0, 0, 1, 1, 0, 16'hE001, -1, "R8");
        do_pop();
        send_buf(4, 0, 0, 1, 1, 0, 16'hE002, -1, "R8");
        repeat (4) @(posedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule